// File: doc/BRIEF.md
# Multicycle RV32I Integer Core

A compact processor core that executes the RV32I base integer instruction set one instruction at a time. Every instruction walks through a fixed state sequence: `ST_FETCH` requests the word at the program counter and waits for the instruction port to accept, `ST_DECODE` classifies the instruction and latches both source registers, `ST_EXEC` computes the ALU result, memory address, link value and next program counter, `ST_MEM` (loads and stores only) drives the data port until it is ready, and `ST_WB` writes the destination register and commits the new program counter before going back to `ST_FETCH`. Two transitions leave the loop for the terminal state `ST_STOP`: `ST_DECODE` goes there when the instruction is an environment call or breakpoint (raising `halt`) or when it is not a legal encoding (raising `illegal`). Other transitions are `ST_FETCH`→`ST_FETCH` and `ST_MEM`→`ST_MEM` while the matching ready is low, and `ST_EXEC`→`ST_WB` for instructions without a memory access.

The core has separate instruction and data ports, each a request/ready handshake, so memories of any latency can be attached. The program counter starts at the `RESET_PC` parameter. A 32-entry register file holds the architectural registers, with register 0 hard-wired to zero. Only reset leaves `ST_STOP`.

Top module: `rv_mc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core requests an instruction (`fetch_req`=1) at `fetch_addr`=`RESET_PC`, with `dmem_req`, `halt` and `illegal` all 0.
- R2: Register-register instructions (opcode 0110011) compute by funct3: 0 add (subtract when bit 30 is 1), 1 shift left, 2 signed less-than, 3 unsigned less-than, 4 xor, 5 logical right shift (arithmetic when bit 30 is 1), 6 or, 7 and; shift amounts are the low 5 bits of the second source, comparisons write 1 or 0.
- R3: Immediate instructions (opcode 0010011) use the same funct3 mapping with the sign-extended 12-bit immediate from bits 31:20 as second operand; shifts take their amount from bits 24:20, bit 30 selects arithmetic right shift, and bit 30 never turns an add into a subtract.
- R4: Branches (opcode 1100011) compare the two sources by funct3 (0 equal, 1 not equal, 4 signed less, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned greater-or-equal) and on success jump to PC plus the sign-extended immediate {bit31, bit7, bits30:25, bits11:8, 0}; otherwise execution continues at PC+4. Backward offsets work.
- R5: JAL (1101111) writes PC+4 to rd and jumps to PC plus {bit31, bits19:12, bit20, bits30:21, 0} sign-extended; JALR (1100111, funct3 0) writes PC+4 to rd and jumps to rs1 plus the I immediate with bit 0 forced to 0.
- R6: LUI (0110111) writes bits 31:12 of the instruction followed by twelve zeros; AUIPC (0010111) writes that value plus the PC of the AUIPC.
- R7: Loads (opcode 0000011, address rs1 plus I immediate) select the byte or halfword at the address's low bits from the 32-bit read word: funct3 0 byte sign-extended, 1 halfword sign-extended, 2 word, 4 byte zero-extended, 5 halfword zero-extended.
- R8: Stores (opcode 0100011, address rs1 plus {bits31:25, bits11:7}) drive `dmem_we`=1 with strobes 0001 shifted left by address bits 1:0 for a byte (funct3 0), 0011 or 1100 chosen by address bit 1 for a halfword (funct3 1) and 1111 for a word (funct3 2), with the data replicated across the lanes so each enabled lane carries the source's low bytes.
- R9: Register 0 always reads as zero; writes to it are discarded.
- R10: Opcode 1110011 with funct3 0 and zero register fields (ECALL, or EBREAK with immediate 1) sets `halt` permanently; no further instruction or data request is made and the instruction has no register effect.
- R11: An unknown opcode, or an invalid funct3/funct7 combination for a known one, sets `illegal` permanently (never together with `halt`) and stops the core with no further requests.
- R12: A request held without ready keeps its address, data, strobes and write enable unchanged until ready, and every instruction is fetched with exactly one completed handshake whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | output | 1 | Instruction request valid |
| fetch_addr | output | 32 | Byte address of the requested instruction |
| fetch_ready | input | 1 | Instruction port accepts; `fetch_instr` valid this cycle |
| fetch_instr | input | 32 | Instruction word |
| dmem_req | output | 1 | Data access request valid |
| dmem_we | output | 1 | 1 for store, 0 for load |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data, replicated across lanes |
| dmem_strb | output | 4 | Byte lane enables for a store |
| dmem_ready | input | 1 | Data port completes the access this cycle |
| dmem_rdata | input | 32 | Load data, valid with `dmem_ready` |
| halt | output | 1 | Environment call or breakpoint reached |
| illegal | output | 1 | Illegal instruction reached |

## Verification
Assertions watch every cycle for the handshake rules of both ports (stable request contents until ready), the silence and stickiness of `halt` and `illegal` and their exclusivity, the legal shapes of the store strobes, and that a source field of register 0 always latches zero. Whether each instruction computes the right value, takes the right branch, lands at the right jump target and moves the right bytes can only be shown by the bench's programs, which sweep every arithmetic, shift, compare and branch encoding over a grid of signed and unsigned boundary operands, every load and store width at every lane offset, and several memory latencies, reading the results back through stores.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int REG_AW  = $clog2(NREGS);
    localparam int NLANES  = XLEN / 8;
    localparam int LANE_AW = $clog2(NLANES);

    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB,
        ST_STOP
    } core_state_e;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
    } alu_op_e;

    typedef enum logic [3:0] {
        K_OP, K_OPIMM, K_LUI, K_AUIPC, K_JAL, K_JALR,
        K_BRANCH, K_LOAD, K_STORE, K_SYSTEM, K_BAD
    } ins_kind_e;

endpackage

// File: rtl/rvc_regfile.sv
module rvc_regfile #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [WIDTH-1:0]         wr_val,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_a,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_b,
    output logic [WIDTH-1:0]         rd_val_a,
    output logic [WIDTH-1:0]         rd_val_b
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx != '0)) begin
            cells[wr_idx] <= wr_val;
        end
    end

    assign rd_val_a = (rd_idx_a == AW'(0)) ? '0 : cells[rd_idx_a];
    assign rd_val_b = (rd_idx_b == AW'(0)) ? '0 : cells[rd_idx_b];

endmodule

// File: rtl/rvc_decode.sv
module rvc_decode
    import rvc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ins_kind_e       kind,
    output alu_op_e         alu_op,
    output logic [XLEN-1:0] imm,
    output logic            rd_we,
    output logic            bad
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;
    alu_op_e arith_op;
    logic    alt;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign f7  = instr[31:25];

    assign imm_i = {{20{instr[31]}}, instr[31:20]};
    assign imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
    assign imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    assign imm_u = {instr[31:12], 12'b0};
    assign imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};

    // bit 30 alters add only for register forms, right shift for both
    assign alt = instr[30] && ((opc == OPC_OP) || (f3 == 3'd5));

    always_comb begin
        unique case (f3)
            3'd0:    arith_op = alt ? ALU_SUB : ALU_ADD;
            3'd1:    arith_op = ALU_SLL;
            3'd2:    arith_op = ALU_SLT;
            3'd3:    arith_op = ALU_SLTU;
            3'd4:    arith_op = ALU_XOR;
            3'd5:    arith_op = alt ? ALU_SRA : ALU_SRL;
            3'd6:    arith_op = ALU_OR;
            default: arith_op = ALU_AND;
        endcase
    end

    always_comb begin
        kind   = K_BAD;
        imm    = imm_i;
        alu_op = ALU_ADD;
        bad    = 1'b0;
        unique case (opc)
            OPC_OP: begin
                kind   = K_OP;
                alu_op = arith_op;
                bad    = !((f7 == 7'h00) ||
                           ((f7 == 7'h20) && ((f3 == 3'd0) || (f3 == 3'd5))));
            end
            OPC_OPIMM: begin
                kind   = K_OPIMM;
                alu_op = arith_op;
                if (f3 == 3'd1)      bad = (f7 != 7'h00);
                else if (f3 == 3'd5) bad = !((f7 == 7'h00) || (f7 == 7'h20));
            end
            OPC_LUI:   begin kind = K_LUI;   imm = imm_u; end
            OPC_AUIPC: begin kind = K_AUIPC; imm = imm_u; end
            OPC_JAL:   begin kind = K_JAL;   imm = imm_j; end
            OPC_JALR: begin
                kind = K_JALR;
                bad  = (f3 != 3'd0);
            end
            OPC_BRANCH: begin
                kind = K_BRANCH;
                imm  = imm_b;
                bad  = (f3 == 3'd2) || (f3 == 3'd3);
            end
            OPC_LOAD: begin
                kind = K_LOAD;
                bad  = (f3 == 3'd3) || (f3 == 3'd6) || (f3 == 3'd7);
            end
            OPC_STORE: begin
                kind = K_STORE;
                imm  = imm_s;
                bad  = (f3 > 3'd2);
            end
            OPC_SYSTEM: begin
                kind = K_SYSTEM;
                bad  = (instr[19:7] != '0) || (instr[31:21] != '0);
            end
            default: bad = 1'b1;
        endcase
    end

    assign rd_we = (kind == K_OP) || (kind == K_OPIMM) || (kind == K_LUI) ||
                   (kind == K_AUIPC) || (kind == K_JAL) || (kind == K_JALR) ||
                   (kind == K_LOAD);

endmodule

// File: rtl/rvc_alu.sv
module rvc_alu
    import rvc_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] sh;
    assign sh = b[SHW-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << sh;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> sh;
            ALU_SRA:  y = XLEN'($signed(a) >>> sh);
            ALU_OR:   y = a | b;
            ALU_AND:  y = a & b;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/rv_mc_core.sv
module rv_mc_core
    import rvc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        fetch_req,
    output logic [31:0] fetch_addr,
    input  logic        fetch_ready,
    input  logic [31:0] fetch_instr,
    output logic        dmem_req,
    output logic        dmem_we,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic [3:0]  dmem_strb,
    input  logic        dmem_ready,
    input  logic [31:0] dmem_rdata,
    output logic        halt,
    output logic        illegal
);
    core_state_e state_q, state_d;

    logic [XLEN-1:0] pc_q, npc_q, instr_q, opa_q, opb_q, res_q;
    logic            halt_q, ill_q;

    ins_kind_e       kind;
    alu_op_e         alu_op;
    logic [XLEN-1:0] imm, rf_a, rf_b, alu_a, alu_b, alu_y;
    logic [XLEN-1:0] pc_plus4, pc_imm, ld_shift, ld_val;
    logic            rd_we, bad, br_taken;
    logic [2:0]      f3;
    logic [REG_AW-1:0] rs1, rs2, rd;
    logic [LANE_AW-1:0] lane;
    logic [NLANES-1:0]  st_strb;
    logic [XLEN-1:0]    st_data;

    assign f3   = instr_q[14:12];
    assign rd   = instr_q[11:7];
    assign rs1  = instr_q[19:15];
    assign rs2  = instr_q[24:20];
    assign lane = res_q[LANE_AW-1:0];

    rvc_decode u_dec (
        .instr  (instr_q),
        .kind   (kind),
        .alu_op (alu_op),
        .imm    (imm),
        .rd_we  (rd_we),
        .bad    (bad)
    );

    rvc_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_rf (
        .clk      (clk),
        .wr_en    ((state_q == ST_WB) && rd_we),
        .wr_idx   (rd),
        .wr_val   (res_q),
        .rd_idx_a (rs1),
        .rd_idx_b (rs2),
        .rd_val_a (rf_a),
        .rd_val_b (rf_b)
    );

    assign alu_a = (kind == K_AUIPC) ? pc_q : (kind == K_LUI) ? '0 : opa_q;
    assign alu_b = (kind == K_OP) ? opb_q : imm;

    rvc_alu u_alu (
        .op (alu_op),
        .a  (alu_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign pc_plus4 = pc_q + XLEN'(4);
    assign pc_imm   = pc_q + imm;

    always_comb begin
        unique case (f3)
            3'd0:    br_taken = (opa_q == opb_q);
            3'd1:    br_taken = (opa_q != opb_q);
            3'd4:    br_taken = ($signed(opa_q) <  $signed(opb_q));
            3'd5:    br_taken = ($signed(opa_q) >= $signed(opb_q));
            3'd6:    br_taken = (opa_q <  opb_q);
            3'd7:    br_taken = (opa_q >= opb_q);
            default: br_taken = 1'b0;
        endcase
    end

    // load lane extraction
    assign ld_shift = dmem_rdata >> {lane, 3'b000};
    always_comb begin
        unique case (f3)
            3'd0:    ld_val = {{24{ld_shift[7]}},  ld_shift[7:0]};
            3'd1:    ld_val = {{16{ld_shift[15]}}, ld_shift[15:0]};
            3'd4:    ld_val = {24'b0, ld_shift[7:0]};
            3'd5:    ld_val = {16'b0, ld_shift[15:0]};
            default: ld_val = ld_shift;
        endcase
    end

    // store lane placement
    always_comb begin
        unique case (f3)
            3'd0: begin
                st_strb = NLANES'(1) << lane;
                st_data = {NLANES{opb_q[7:0]}};
            end
            3'd1: begin
                st_strb = lane[1] ? 4'b1100 : 4'b0011;
                st_data = {2{opb_q[15:0]}};
            end
            default: begin
                st_strb = '1;
                st_data = opb_q;
            end
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  if (fetch_ready) state_d = ST_DECODE;
            ST_DECODE: state_d = (bad || (kind == K_SYSTEM)) ? ST_STOP : ST_EXEC;
            ST_EXEC:   state_d = ((kind == K_LOAD) || (kind == K_STORE)) ? ST_MEM : ST_WB;
            ST_MEM:    if (dmem_ready) state_d = ST_WB;
            ST_WB:     state_d = ST_FETCH;
            ST_STOP:   state_d = ST_STOP;
            default:   state_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            npc_q   <= RESET_PC;
            instr_q <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            res_q   <= '0;
            halt_q  <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: if (fetch_ready) instr_q <= fetch_instr;
                ST_DECODE: begin
                    opa_q <= rf_a;
                    opb_q <= rf_b;
                    if (bad)                    ill_q  <= 1'b1;
                    else if (kind == K_SYSTEM)  halt_q <= 1'b1;
                end
                ST_EXEC: begin
                    res_q <= ((kind == K_JAL) || (kind == K_JALR)) ? pc_plus4 : alu_y;
                    unique case (kind)
                        K_JAL:    npc_q <= pc_imm;
                        K_JALR:   npc_q <= {alu_y[XLEN-1:1], 1'b0};
                        K_BRANCH: npc_q <= br_taken ? pc_imm : pc_plus4;
                        default:  npc_q <= pc_plus4;
                    endcase
                end
                ST_MEM: if (dmem_ready && (kind == K_LOAD)) res_q <= ld_val;
                ST_WB:  pc_q <= npc_q;
                default: ;
            endcase
        end
    end

    // port outputs
    always_comb begin
        fetch_req  = (state_q == ST_FETCH);
        fetch_addr = pc_q;
        dmem_req   = (state_q == ST_MEM);
        dmem_we    = (state_q == ST_MEM) && (kind == K_STORE);
        dmem_addr  = res_q;
        dmem_wdata = st_data;
        dmem_strb  = (kind == K_STORE) ? st_strb : '0;
        halt       = halt_q;
        illegal    = ill_q;
    end

    // R12
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ready) |=> (fetch_req && $stable(fetch_addr)));

    // R12
    dmem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_req && !dmem_ready) |=> (dmem_req && $stable(dmem_addr) &&
            $stable(dmem_we) && $stable(dmem_strb) && $stable(dmem_wdata)));

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!fetch_req && !dmem_req));

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R11
    illegal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (illegal && !fetch_req && !dmem_req));

    // R11
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt && illegal));

    // R9
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DECODE) && (rs1 == '0)) |=> (opa_q == '0));

    // R8
    strb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_req && dmem_we) |-> ($countones(dmem_strb) == 1 ||
            dmem_strb == 4'b0011 || dmem_strb == 4'b1100 || dmem_strb == 4'b1111));

endmodule

// File: tb/test_rv_mc_core.sv
`timescale 1ns/1ps
module test_rv_mc_core;

    localparam logic [31:0] RPC = 32'h0000_0100;
    localparam logic [6:0] O_OP = 7'b0110011, O_OPI = 7'b0010011,
                           O_LD = 7'b0000011, O_LUI = 7'b0110111,
                           O_AUIPC = 7'b0010111, O_JALR = 7'b1100111;
    localparam logic [31:0] EBRK = 32'h0010_0073, ECAL = 32'h0000_0073;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req, fetch_ready, dmem_req, dmem_we, dmem_ready, halt, illegal;
    logic [31:0] fetch_addr, fetch_instr, dmem_addr, dmem_wdata, dmem_rdata;
    logic [3:0]  dmem_strb;

    logic [31:0] imem [32];
    logic [31:0] dinit [16];
    logic [31:0] dmem [16];
    int          wait_cfg = 0;
    int          fetch_cnt, fwait, dwait;
    int          n_chk = 0, n_err = 0, run_no = 0;

    always #4 clk = ~clk;

    rv_mc_core #(.RESET_PC(RPC)) i_rv_mc_core (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_instr(fetch_instr),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_strb(dmem_strb),
        .dmem_ready(dmem_ready), .dmem_rdata(dmem_rdata),
        .halt(halt), .illegal(illegal)
    );

    // memory model, changes inputs only on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            fetch_ready <= 1'b0; dmem_ready <= 1'b0;
            fetch_instr <= '0;   dmem_rdata <= '0;
            fetch_cnt <= 0; fwait <= 0; dwait <= 0;
            for (int i = 0; i < 16; i++) dmem[i] <= dinit[i];
        end else begin
            if (fetch_req && !fetch_ready) begin
                if (fwait >= wait_cfg) begin
                    fetch_ready <= 1'b1;
                    fetch_instr <= imem[5'((fetch_addr - RPC) >> 2)];
                    fetch_cnt   <= fetch_cnt + 1;
                    fwait       <= 0;
                end else fwait <= fwait + 1;
            end else fetch_ready <= 1'b0;
            if (dmem_req && !dmem_ready) begin
                if (dwait >= wait_cfg) begin
                    dmem_ready <= 1'b1;
                    dmem_rdata <= dmem[dmem_addr[5:2]];
                    if (dmem_we) begin
                        for (int l = 0; l < 4; l++)
                            if (dmem_strb[l]) dmem[dmem_addr[5:2]][8*l +: 8] <= dmem_wdata[8*l +: 8];
                    end
                    dwait <= 0;
                end else dwait <= dwait + 1;
            end else dmem_ready <= 1'b0;
        end
    end

    function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, input int rs1,
                                        input logic [2:0] f3, input int rd);
        return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), O_OP};
    endfunction
    function automatic logic [31:0] e_i(input logic [11:0] im, input int rs1,
                                        input logic [2:0] f3, input int rd, input logic [6:0] op);
        return {im, 5'(rs1), f3, 5'(rd), op};
    endfunction
    function automatic logic [31:0] e_s(input logic [11:0] im, input int rs2, input logic [2:0] f3);
        return {im[11:5], 5'(rs2), 5'd0, f3, im[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] e_b(input logic [12:0] im, input int rs2, input int rs1,
                                        input logic [2:0] f3);
        return {im[12], im[10:5], 5'(rs2), 5'(rs1), f3, im[4:1], im[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] e_j(input logic [20:0] im, input int rd);
        return {im[20], im[10:1], im[11], im[19:12], 5'(rd), 7'b1101111};
    endfunction
    function automatic logic [31:0] lw(input int rd, input int off);
        return e_i(12'(off), 0, 3'd2, rd, O_LD);
    endfunction
    function automatic logic [31:0] sw(input int rs, input int off);
        return e_s(12'(off), rs, 3'd2);
    endfunction
    function automatic logic [31:0] addi(input int rd, input int rs, input int v);
        return e_i(12'(v), rs, 3'd0, rd, O_OPI);
    endfunction

    function automatic logic [31:0] ref_alu(input logic [2:0] f3, input logic alt,
                                            input logic [31:0] a, input logic [31:0] b);
        case (f3)
            3'd0: return alt ? a - b : a + b;
            3'd1: return a << b[4:0];
            3'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            3'd3: return (a < b) ? 32'd1 : 32'd0;
            3'd4: return a ^ b;
            3'd5: return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic logic ref_br(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
        case (f3)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd4: return $signed(a) < $signed(b);
            3'd5: return $signed(a) >= $signed(b);
            3'd6: return a < b;
            default: return a >= b;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 32; i++) imem[i] = 32'h0;
        for (int i = 0; i < 16; i++) dinit[i] = 32'h0;
    endtask

    task automatic run_core(input bit chk_reset);
        int cyc;
        wait_cfg = run_no % 4;
        run_no++;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        if (chk_reset) begin
            check("R1", "fetch address after reset", fetch_addr, RPC);
            check("R1", "req/dreq/halt/illegal after reset",
                  {28'd0, fetch_req, dmem_req, halt, illegal}, 32'b1000);
        end
        cyc = 0;
        while (!(halt || illegal) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 3000) check("R12", "program completion", 32'd0, 32'd1);
    endtask

    logic [31:0] vals [6];
    logic [11:0] imms [6];

    initial begin
        vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'h7;
        vals[3] = 32'hFFFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
        imms[0] = 12'h000; imms[1] = 12'h001; imms[2] = 12'hFFF;
        imms[3] = 12'h7FF; imms[4] = 12'h800; imms[5] = 12'h555;

        // R1 reset state, R10 halt, R12 fetch count on a tiny program
        clear_prog();
        imem[0] = addi(3, 0, 9); imem[1] = sw(3, 8); imem[2] = EBRK;
        run_core(1);
        check("R10", "halt/illegal after ebreak", {30'd0, halt, illegal}, 32'b10);
        check("R12", "fetch handshakes", 32'(fetch_cnt), 32'd3);
        check("R3", "addi result", dmem[2], 32'd9);
        repeat (10) @(negedge clk);
        check("R10", "no fetch after halt", {31'd0, fetch_req}, 32'd0);
        check("R10", "fetch count frozen", 32'(fetch_cnt), 32'd3);

        // R2 register-register sweep
        for (int k = 0; k < 10; k++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 6; ib++) begin
                    logic [2:0] f3; logic alt;
                    f3  = (k < 8) ? 3'(k) : ((k == 8) ? 3'd0 : 3'd5);
                    alt = (k >= 8);
                    clear_prog();
                    dinit[0] = vals[ia]; dinit[1] = vals[ib];
                    imem[0] = lw(1, 0); imem[1] = lw(2, 4);
                    imem[2] = e_r(alt ? 7'h20 : 7'h00, 2, 1, f3, 3);
                    imem[3] = sw(3, 8); imem[4] = EBRK;
                    run_core(0);
                    check("R2", $sformatf("f3=%0d alt=%0d a=%h b=%h", f3, alt, vals[ia], vals[ib]),
                          dmem[2], ref_alu(f3, alt, vals[ia], vals[ib]));
                end
            end
        end

        // R3 immediate arithmetic sweep (non-shift)
        for (int k = 0; k < 6; k++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ii = 0; ii < 6; ii++) begin
                    logic [2:0] f3;
                    case (k) 0: f3 = 3'd0; 1: f3 = 3'd2; 2: f3 = 3'd3;
                             3: f3 = 3'd4; 4: f3 = 3'd6; default: f3 = 3'd7; endcase
                    clear_prog();
                    dinit[0] = vals[ia];
                    imem[0] = lw(1, 0); imem[1] = e_i(imms[ii], 1, f3, 3, O_OPI);
                    imem[2] = sw(3, 8); imem[3] = EBRK;
                    run_core(0);
                    check("R3", $sformatf("f3=%0d a=%h imm=%h", f3, vals[ia], imms[ii]),
                          dmem[2], ref_alu(f3, 1'b0, vals[ia], {{20{imms[ii][11]}}, imms[ii]}));
                end
            end
        end

        // R3 shift-immediate sweep
        for (int k = 0; k < 3; k++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int is = 0; is < 4; is++) begin
                    logic [2:0] f3; logic alt; logic [4:0] sh;
                    f3  = (k == 0) ? 3'd1 : 3'd5;
                    alt = (k == 2);
                    case (is) 0: sh = 5'd0; 1: sh = 5'd1; 2: sh = 5'd31; default: sh = 5'd13; endcase
                    clear_prog();
                    dinit[0] = vals[ia];
                    imem[0] = lw(1, 0);
                    imem[1] = e_i({alt ? 7'h20 : 7'h00, sh}, 1, f3, 3, O_OPI);
                    imem[2] = sw(3, 8); imem[3] = EBRK;
                    run_core(0);
                    check("R3", $sformatf("shift f3=%0d alt=%0d a=%h sh=%0d", f3, alt, vals[ia], sh),
                          dmem[2], ref_alu(f3, alt, vals[ia], {27'd0, sh}));
                end
            end
        end

        // R4 branch sweep
        for (int k = 0; k < 6; k++) begin
            for (int ia = 0; ia < 6; ia++) begin
                for (int ib = 0; ib < 6; ib++) begin
                    logic [2:0] f3;
                    f3 = (k < 2) ? 3'(k) : 3'(k + 2);
                    clear_prog();
                    dinit[0] = vals[ia]; dinit[1] = vals[ib];
                    imem[0] = lw(1, 0); imem[1] = lw(2, 4); imem[2] = addi(3, 0, 1);
                    imem[3] = e_b(13'd8, 2, 1, f3); imem[4] = addi(3, 0, 2);
                    imem[5] = sw(3, 8); imem[6] = EBRK;
                    run_core(0);
                    check("R4", $sformatf("br f3=%0d a=%h b=%h", f3, vals[ia], vals[ib]),
                          dmem[2], ref_br(f3, vals[ia], vals[ib]) ? 32'd1 : 32'd2);
                end
            end
        end

        // R4 backward branch loop: 3 iterations of +5
        clear_prog();
        imem[0] = addi(1, 0, 3); imem[1] = addi(3, 0, 0); imem[2] = addi(3, 3, 5);
        imem[3] = addi(1, 1, -1); imem[4] = e_b(13'h1FF8, 0, 1, 3'd1);
        imem[5] = sw(3, 8); imem[6] = EBRK;
        run_core(0);
        check("R4", "backward branch loop", dmem[2], 32'd15);

        // R5 JAL forward/backward with links
        clear_prog();
        imem[0] = e_j(21'd12, 5);          // -> idx3
        imem[1] = addi(3, 0, 77);
        imem[2] = e_b(13'd12, 0, 0, 3'd0); // -> idx5
        imem[3] = e_j(21'h1FFFF8, 6);      // -8 -> idx1
        imem[4] = addi(3, 0, 1);
        imem[5] = sw(5, 0); imem[6] = sw(6, 4); imem[7] = sw(3, 8); imem[8] = EBRK;
        run_core(0);
        check("R5", "jal link forward", dmem[0], RPC + 32'd4);
        check("R5", "jal link backward", dmem[1], RPC + 32'd16);
        check("R5", "jal path", dmem[2], 32'd77);

        // R5 JALR with odd target, bit 0 cleared
        clear_prog();
        imem[0] = addi(3, 0, 55); imem[1] = addi(1, 0, 32'h10F);
        imem[2] = e_i(12'd6, 1, 3'd0, 7, O_JALR);   // 0x115 -> 0x114 (idx5)
        imem[3] = addi(3, 0, 1); imem[4] = addi(3, 0, 2);
        imem[5] = sw(7, 0); imem[6] = sw(3, 4); imem[7] = EBRK;
        run_core(0);
        check("R5", "jalr link", dmem[0], RPC + 32'd12);
        check("R5", "jalr target skips", dmem[1], 32'd55);

        // R6 LUI / AUIPC
        clear_prog();
        imem[0] = {20'hABCDE, 5'd1, O_LUI};
        imem[1] = {20'h12345, 5'd2, O_AUIPC};
        imem[2] = sw(1, 0); imem[3] = sw(2, 4); imem[4] = EBRK;
        run_core(0);
        check("R6", "lui", dmem[0], 32'hABCD_E000);
        check("R6", "auipc", dmem[1], 32'h1234_5000 + RPC + 32'd4);

        // R7 loads at every lane
        for (int k = 0; k < 13; k++) begin
            logic [2:0] f3; int off; logic [31:0] w, s, exp;
            w = 32'h80F1_7F02;
            if (k < 4)       begin f3 = 3'd0; off = k; end
            else if (k < 8)  begin f3 = 3'd4; off = k - 4; end
            else if (k < 10) begin f3 = 3'd1; off = (k - 8) * 2; end
            else if (k < 12) begin f3 = 3'd5; off = (k - 10) * 2; end
            else             begin f3 = 3'd2; off = 0; end
            s = w >> (8 * off);
            case (f3)
                3'd0: exp = {{24{s[7]}}, s[7:0]};
                3'd4: exp = {24'd0, s[7:0]};
                3'd1: exp = {{16{s[15]}}, s[15:0]};
                3'd5: exp = {16'd0, s[15:0]};
                default: exp = s;
            endcase
            clear_prog();
            dinit[0] = w;
            imem[0] = e_i(12'(off), 0, f3, 3, O_LD); imem[1] = sw(3, 8); imem[2] = EBRK;
            run_core(0);
            check("R7", $sformatf("load f3=%0d off=%0d", f3, off), dmem[2], exp);
        end

        // R8 stores at every lane
        for (int k = 0; k < 7; k++) begin
            logic [2:0] f3; int off; logic [31:0] exp;
            exp = 32'hAAAA_AAAA;
            if (k < 4)      begin f3 = 3'd0; off = k; exp[8*off +: 8] = 8'h44; end
            else if (k < 6) begin f3 = 3'd1; off = (k - 4) * 2; exp[8*off +: 16] = 16'h3344; end
            else            begin f3 = 3'd2; off = 0; exp = 32'h1122_3344; end
            clear_prog();
            dinit[0] = 32'h1122_3344; dinit[3] = 32'hAAAA_AAAA;
            imem[0] = lw(1, 0); imem[1] = e_s(12'(12 + off), 1, f3); imem[2] = EBRK;
            run_core(0);
            check("R8", $sformatf("store f3=%0d off=%0d", f3, off), dmem[3], exp);
        end

        // R9 register 0
        clear_prog();
        dinit[0] = 32'hDEAD_BEEF; dinit[1] = 32'h5;
        imem[0] = addi(0, 0, 123); imem[1] = addi(3, 0, 7);
        imem[2] = sw(3, 4); imem[3] = sw(0, 0); imem[4] = EBRK;
        run_core(0);
        check("R9", "x0 after write", dmem[0], 32'd0);
        check("R9", "x0 as source", dmem[1], 32'd7);

        // R10 ECALL stops before the following store
        clear_prog();
        dinit[2] = 32'h0000_00EE;
        imem[0] = addi(3, 0, 9); imem[1] = ECAL; imem[2] = sw(3, 8);
        run_core(0);
        check("R10", "ecall halt/illegal", {30'd0, halt, illegal}, 32'b10);
        check("R10", "nothing after ecall", dmem[2], 32'h0000_00EE);
        check("R10", "ecall fetch count", 32'(fetch_cnt), 32'd2);

        // R11 unknown opcode
        clear_prog();
        imem[0] = addi(3, 0, 5); imem[1] = sw(3, 0); imem[2] = 32'h0000_007F; imem[3] = sw(0, 0);
        run_core(0);
        repeat (8) @(negedge clk);
        check("R11", "unknown opcode flags", {30'd0, halt, illegal}, 32'b01);
        check("R11", "store before illegal kept", dmem[0], 32'd5);
        check("R11", "no fetch after illegal", 32'(fetch_cnt), 32'd3);

        // R11 invalid funct7 on a register-register form
        clear_prog();
        dinit[2] = 32'h0000_0033;
        imem[0] = e_r(7'h01, 2, 1, 3'd0, 3); imem[1] = sw(0, 8);
        run_core(0);
        check("R11", "bad funct7 flags", {30'd0, halt, illegal}, 32'b01);
        check("R11", "bad funct7 no effect", dmem[2], 32'h0000_0033);

        // R11 invalid load funct3
        clear_prog();
        imem[0] = e_i(12'd0, 0, 3'd3, 3, O_LD); imem[1] = EBRK;
        run_core(0);
        check("R11", "bad load funct3 flags", {30'd0, halt, illegal}, 32'b01);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R12: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule